// File: doc/BRIEF.md
# Time-Slot Channel Activation Sequencer

This block keeps the per-slot scheduling state for a frame of sixteen time slots. A free-running segment timer splits each frame into one segment per slot and visits the slots in ascending order. At the first cycle of a slot's segment the sequencer runs the handling for that slot. When the slot's TX and RX routines are not both active, this is the inactive handling: any control word the host has queued for the slot is applied, which links the slot to a channel, copies a default coefficient table into that channel, or switches the routines on. Routine shutdown requests are applied at the slot's own segment in every case. After the handling, the sequencer serves at most one queued host request at a single poll cycle and then idles until the segment ends.

The host reaches the block through a one-entry request port. It can queue a control word for a slot, write or read one coefficient of a channel, or write one entry of a default table. A default copy moves one coefficient per clock. Downstream processing observes the current slot's routine selections, link flag and channel pointer on the status outputs.

Top module: `slot_activation_seq`

## Requirements
- R1: After reset the segment timer starts at slot 0. Each segment lasts SEG_CYCLES clocks, and `seg_start` is high only in its first clock. `cur_slot` counts 0 to NUM_SLOTS-1 and then wraps to 0.
- R2: The request port holds a single pending request. A request is taken when `host_valid` and `host_ready` are both high. `host_ready` then stays low until the request is served at the segment's single `poll` cycle, which comes after the handling and any copy. Exactly one `poll` occurs per segment.
- R3: The `host_cmd` codes are: 0 queues a control word for slot `host_sel`; 1 writes coefficient `host_idx` of channel `host_sel`; 2 writes entry `host_idx` of default table `host_sel` bit 0; 3 reads coefficient `host_idx` of channel `host_sel`.
- R4: In a control word, bit 1 is the link flag and bits 11:8 are the channel. If the link flag is set and the slot is inactive at its next segment start, that segment sets the slot's channel pointer to the channel and sets its linked flag.
- R5: Bits 3:2 of a control word select default tables, with bit 2 for table 0 and bit 3 for table 1. With the link flag set in an inactive segment and any select bit set, the lowest-numbered selected table is copied into the channel. The copy moves one coefficient per clock, and `busy` is high for exactly NUM_COEF clocks.
- R6: Bit 0 of a control word is the power-up flag. In an inactive segment it sets both the TX and RX active bits of the slot.
- R7: Bit 4 clears the TX active bit and bit 5 clears the RX active bit. Each takes effect at the slot's next segment, whether the slot is active or not, and it overrides bit 0 of the same word.
- R8: In a segment where both routines of the slot are active, the link flag, the table selects and the power-up flag are discarded. The pointer, the linked flag and the channel storage stay unchanged.
- R9: Reset leaves every slot with both routines inactive, no link and pointer 0. It also empties the request port, sets `busy` low and clears all coefficient storage to 0.
- R10: A read request returns the stored coefficient on `rd_data`, with `rd_valid` high for one clock. That clock is the one after the `poll` cycle that served the request.
- R11: A control word queued for a slot replaces any earlier word for the same slot that has not yet been applied.
- R12: The status outputs `cur_tx_act`, `cur_rx_act`, `cur_linked` and `cur_chan` show the state of `cur_slot`. They change only in the first clock of a segment or in the clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host request strobe |
| host_ready | output | 1 | Request port empty |
| host_cmd | input | 2 | Request kind (R3) |
| host_sel | input | SEL_W | Slot, channel or table number |
| host_idx | input | IDX_W | Coefficient index |
| host_wdata | input | COEF_W | Write data or control word |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | COEF_W | Read data |
| seg_start | output | 1 | First clock of a segment |
| cur_slot | output | SLOT_W | Slot of the current segment |
| cur_tx_act | output | 1 | TX routine active for current slot |
| cur_rx_act | output | 1 | RX routine active for current slot |
| cur_linked | output | 1 | Current slot linked to a channel |
| cur_chan | output | CH_W | Channel pointer of current slot |
| busy | output | 1 | Default copy in progress |
| poll | output | 1 | Host poll cycle of the segment |

## Verification
The assertions assume that SEG_CYCLES leaves room for a full copy, the poll cycle and at least one idle clock. They also assume that the host drives `host_valid` for a single clock and only when `host_ready` is high, and that `host_sel` stays within the number of slots, channels or tables. The stimulus keeps to these limits. Every request is issued by one task that waits for `host_ready` at a falling edge and drops the strobe after one rising edge. Random selectors are drawn inside the legal ranges. Control words mix the link, select, power-up and shutdown bits, so both active and inactive segments occur.

// File: rtl/sas_pkg.sv
package sas_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_COPY = 2'd1,
        PH_POLL = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        CMD_CTRL    = 2'd0,
        CMD_COEF_WR = 2'd1,
        CMD_DFLT_WR = 2'd2,
        CMD_COEF_RD = 2'd3
    } cmd_e;

    // control word bit positions (host-visible encoding)
    localparam int CW_GO  = 0;
    localparam int CW_MC  = 1;
    localparam int CW_DF  = 2;
    localparam int CW_CH  = 8;

endpackage

// File: rtl/sas_seg_timer.sv
module sas_seg_timer #(
    parameter  int NUM_SLOTS  = 16,
    parameter  int SEG_CYCLES = 24,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int CNT_W      = $clog2(SEG_CYCLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              seg_start,
    output logic [SLOT_W-1:0] slot
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == CNT_W'(SEG_CYCLES - 1)) begin
            tmr_d.cnt  = '0;
            tmr_d.slot = (tmr_q.slot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : tmr_q.slot + 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign seg_start = (tmr_q.cnt == '0);
    assign slot      = tmr_q.slot;

endmodule

// File: rtl/sas_coef_store.sv
module sas_coef_store #(
    parameter  int NUM_CH   = 16,
    parameter  int NUM_COEF = 16,
    parameter  int NUM_DFLT = 2,
    parameter  int COEF_W   = 16,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int IDX_W    = $clog2(NUM_COEF),
    localparam int TBL_W    = (NUM_DFLT > 1) ? $clog2(NUM_DFLT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_we,
    input  logic [CH_W-1:0]   ch_wsel,
    input  logic [IDX_W-1:0]  ch_widx,
    input  logic [COEF_W-1:0] ch_wdata,
    input  logic [CH_W-1:0]   ch_rsel,
    input  logic [IDX_W-1:0]  ch_ridx,
    output logic [COEF_W-1:0] ch_rdata,
    input  logic              df_we,
    input  logic [TBL_W-1:0]  df_wsel,
    input  logic [IDX_W-1:0]  df_widx,
    input  logic [COEF_W-1:0] df_wdata,
    input  logic [TBL_W-1:0]  df_rsel,
    input  logic [IDX_W-1:0]  df_ridx,
    output logic [COEF_W-1:0] df_rdata
);

    logic [COEF_W-1:0] chan_q [NUM_CH][NUM_COEF];
    logic [COEF_W-1:0] dflt_q [NUM_DFLT][NUM_COEF];

    // storage arrays are written in place; no next-state copy of the whole array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++)
                for (int i = 0; i < NUM_COEF; i++)
                    chan_q[c][i] <= '0;
        end else if (ch_we) begin
            chan_q[ch_wsel][ch_widx] <= ch_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_DFLT; t++)
                for (int i = 0; i < NUM_COEF; i++)
                    dflt_q[t][i] <= '0;
        end else if (df_we) begin
            dflt_q[df_wsel][df_widx] <= df_wdata;
        end
    end

    assign ch_rdata = chan_q[ch_rsel][ch_ridx];
    assign df_rdata = dflt_q[df_rsel][df_ridx];

endmodule

// File: rtl/slot_activation_seq.sv
module slot_activation_seq
    import sas_pkg::*;
#(
    parameter  int NUM_SLOTS  = 16,
    parameter  int NUM_CH     = 16,
    parameter  int NUM_COEF   = 16,
    parameter  int NUM_DFLT   = 2,
    parameter  int COEF_W     = 16,
    parameter  int SEG_CYCLES = 24,   // must be at least NUM_COEF + 3
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int CH_W       = $clog2(NUM_CH),
    localparam int IDX_W      = $clog2(NUM_COEF),
    localparam int TBL_W      = (NUM_DFLT > 1) ? $clog2(NUM_DFLT) : 1,
    localparam int SEL_W      = (SLOT_W > CH_W) ? SLOT_W : CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    output logic              host_ready,
    input  logic [1:0]        host_cmd,
    input  logic [SEL_W-1:0]  host_sel,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [COEF_W-1:0] host_wdata,
    output logic              rd_valid,
    output logic [COEF_W-1:0] rd_data,
    output logic              seg_start,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              cur_tx_act,
    output logic              cur_rx_act,
    output logic              cur_linked,
    output logic [CH_W-1:0]   cur_chan,
    output logic              busy,
    output logic              poll
);

    localparam int CW_TXOFF = CW_DF + NUM_DFLT;
    localparam int CW_RXOFF = CW_TXOFF + 1;

    typedef struct packed {
        logic                go;
        logic                mc;
        logic [NUM_DFLT-1:0] df;
        logic                txo;
        logic                rxo;
        logic [CH_W-1:0]     ch;
    } cwf_t;

    typedef struct packed {
        phase_e                         ph;
        logic [IDX_W-1:0]               cidx;
        logic [TBL_W-1:0]               ctbl;
        logic [CH_W-1:0]                cch;
        logic                           pend;
        logic [1:0]                     pcmd;
        logic [SEL_W-1:0]               psel;
        logic [IDX_W-1:0]               pidx;
        logic [COEF_W-1:0]              pdata;
        logic [NUM_SLOTS-1:0]           tx;
        logic [NUM_SLOTS-1:0]           rx;
        logic [NUM_SLOTS-1:0]           lnk;
        logic [NUM_SLOTS-1:0]           cwv;
        logic [NUM_SLOTS-1:0][CH_W-1:0] ptr;
        cwf_t [NUM_SLOTS-1:0]           cw;
        logic                           rdv;
        logic [COEF_W-1:0]              rdd;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              tm_start;
    logic [SLOT_W-1:0] tm_slot;

    logic              ch_we;
    logic [CH_W-1:0]   ch_wsel;
    logic [IDX_W-1:0]  ch_widx;
    logic [COEF_W-1:0] ch_wdata;
    logic [COEF_W-1:0] ch_rdata;
    logic              df_we;
    logic [COEF_W-1:0] df_rdata;

    cwf_t              hcw;
    cwf_t              scw;
    logic              inact;
    logic [TBL_W-1:0]  lo_tbl;

    sas_seg_timer #(
        .NUM_SLOTS  (NUM_SLOTS),
        .SEG_CYCLES (SEG_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .seg_start (tm_start),
        .slot      (tm_slot)
    );

    sas_coef_store #(
        .NUM_CH   (NUM_CH),
        .NUM_COEF (NUM_COEF),
        .NUM_DFLT (NUM_DFLT),
        .COEF_W   (COEF_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ch_we    (ch_we),
        .ch_wsel  (ch_wsel),
        .ch_widx  (ch_widx),
        .ch_wdata (ch_wdata),
        .ch_rsel  (seq_q.psel[CH_W-1:0]),
        .ch_ridx  (seq_q.pidx),
        .ch_rdata (ch_rdata),
        .df_we    (df_we),
        .df_wsel  (seq_q.psel[TBL_W-1:0]),
        .df_widx  (seq_q.pidx),
        .df_wdata (seq_q.pdata),
        .df_rsel  (seq_q.ctbl),
        .df_ridx  (seq_q.cidx),
        .df_rdata (df_rdata)
    );

    // decode of the pending word as a control word
    always_comb begin
        hcw.go  = seq_q.pdata[CW_GO];
        hcw.mc  = seq_q.pdata[CW_MC];
        hcw.df  = seq_q.pdata[CW_DF +: NUM_DFLT];
        hcw.txo = seq_q.pdata[CW_TXOFF];
        hcw.rxo = seq_q.pdata[CW_RXOFF];
        hcw.ch  = seq_q.pdata[CW_CH +: CH_W];
    end

    // queued word of the current slot and its table priority
    always_comb begin
        scw    = seq_q.cw[tm_slot];
        inact  = !(seq_q.tx[tm_slot] && seq_q.rx[tm_slot]);
        lo_tbl = '0;
        for (int k = NUM_DFLT - 1; k >= 0; k--)
            if (scw.df[k]) lo_tbl = TBL_W'(k);
    end

    always_comb begin
        seq_d    = seq_q;
        seq_d.rdv = 1'b0;
        ch_we    = 1'b0;
        ch_wsel  = seq_q.psel[CH_W-1:0];
        ch_widx  = seq_q.pidx;
        ch_wdata = seq_q.pdata;
        df_we    = 1'b0;

        if (host_valid && !seq_q.pend) begin
            seq_d.pend  = 1'b1;
            seq_d.pcmd  = host_cmd;
            seq_d.psel  = host_sel;
            seq_d.pidx  = host_idx;
            seq_d.pdata = host_wdata;
        end

        if (tm_start) begin
            seq_d.ph = PH_POLL;
            if (seq_q.cwv[tm_slot]) begin
                seq_d.cwv[tm_slot] = 1'b0;
                if (inact && scw.mc) begin
                    seq_d.ptr[tm_slot] = scw.ch;
                    seq_d.lnk[tm_slot] = 1'b1;
                    if (|scw.df) begin
                        seq_d.ctbl = lo_tbl;
                        seq_d.cch  = scw.ch;
                        seq_d.cidx = '0;
                        seq_d.ph   = PH_COPY;
                    end
                end
                if (inact && scw.go) begin
                    seq_d.tx[tm_slot] = 1'b1;
                    seq_d.rx[tm_slot] = 1'b1;
                end
                if (scw.txo) seq_d.tx[tm_slot] = 1'b0;
                if (scw.rxo) seq_d.rx[tm_slot] = 1'b0;
            end
        end else begin
            unique case (seq_q.ph)
                PH_COPY: begin
                    ch_we    = 1'b1;
                    ch_wsel  = seq_q.cch;
                    ch_widx  = seq_q.cidx;
                    ch_wdata = df_rdata;
                    seq_d.cidx = seq_q.cidx + 1'b1;
                    if (seq_q.cidx == IDX_W'(NUM_COEF - 1)) seq_d.ph = PH_POLL;
                end
                PH_POLL: begin
                    seq_d.ph = PH_IDLE;
                    if (seq_q.pend) begin
                        seq_d.pend = 1'b0;
                        unique case (cmd_e'(seq_q.pcmd))
                            CMD_CTRL: begin
                                seq_d.cw[seq_q.psel[SLOT_W-1:0]]  = hcw;
                                seq_d.cwv[seq_q.psel[SLOT_W-1:0]] = 1'b1;
                            end
                            CMD_COEF_WR: ch_we = 1'b1;
                            CMD_DFLT_WR: df_we = 1'b1;
                            CMD_COEF_RD: begin
                                seq_d.rdv = 1'b1;
                                seq_d.rdd = ch_rdata;
                            end
                            default: ;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.ph <= PH_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign host_ready = !seq_q.pend;
    assign rd_valid   = seq_q.rdv;
    assign rd_data    = seq_q.rdd;
    assign seg_start  = tm_start;
    assign cur_slot   = tm_slot;
    assign cur_tx_act = seq_q.tx[tm_slot];
    assign cur_rx_act = seq_q.rx[tm_slot];
    assign cur_linked = seq_q.lnk[tm_slot];
    assign cur_chan   = seq_q.ptr[tm_slot];
    assign busy       = (seq_q.ph == PH_COPY);
    assign poll       = (seq_q.ph == PH_POLL) && !tm_start;

endmodule

// File: rtl/sas_checker.sv
module sas_checker #(
    parameter  int NUM_SLOTS  = 16,
    parameter  int NUM_COEF   = 16,
    parameter  int SEG_CYCLES = 24,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int SC_W       = $clog2(SEG_CYCLES + 1) + 1,
    localparam int BC_W       = $clog2(NUM_COEF + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_valid,
    input logic              host_ready,
    input logic              rd_valid,
    input logic              seg_start,
    input logic [SLOT_W-1:0] cur_slot,
    input logic              cur_tx_act,
    input logic              cur_rx_act,
    input logic              busy,
    input logic              poll
);

    logic [SC_W-1:0]   scnt;
    logic [BC_W-1:0]   bcnt;
    logic [1:0]        pcnt;
    logic [SLOT_W-1:0] last_slot;
    logic              seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scnt      <= '0;
            bcnt      <= '0;
            pcnt      <= '0;
            last_slot <= '0;
            seen      <= 1'b0;
        end else begin
            scnt <= seg_start ? SC_W'(1) : scnt + 1'b1;
            bcnt <= busy ? bcnt + 1'b1 : '0;
            if (seg_start)      pcnt <= '0;
            else if (poll)      pcnt <= pcnt + 1'b1;
            if (seg_start) begin
                last_slot <= cur_slot;
                seen      <= 1'b1;
            end
        end
    end

    assert_seg_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        seg_start && seen |-> scnt == SC_W'(SEG_CYCLES));

    assert_slot_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        seg_start && seen |->
            cur_slot == ((last_slot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : last_slot + 1'b1));

    assert_one_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seg_start && seen |-> pcnt == 2'd1);

    assert_pending_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid && host_ready |=> !host_ready);

    assert_copy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> bcnt == BC_W'(NUM_COEF));

    assert_rd_after_poll_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(poll));

    assert_tx_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_tx_act) |-> (seg_start || $past(seg_start)));

    assert_rx_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_rx_act) |-> (seg_start || $past(seg_start)));

endmodule

bind slot_activation_seq sas_checker #(
    .NUM_SLOTS  (NUM_SLOTS),
    .NUM_COEF   (NUM_COEF),
    .SEG_CYCLES (SEG_CYCLES)
) u_sas_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_ready (host_ready),
    .rd_valid   (rd_valid),
    .seg_start  (seg_start),
    .cur_slot   (cur_slot),
    .cur_tx_act (cur_tx_act),
    .cur_rx_act (cur_rx_act),
    .busy       (busy),
    .poll       (poll)
);

// File: tb/test_slot_activation_seq.sv
module test_slot_activation_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NS   = 16;
    localparam int NC   = 16;
    localparam int NK   = 16;
    localparam int SEG  = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_ready;
    logic [1:0]  host_cmd = '0;
    logic [3:0]  host_sel = '0;
    logic [3:0]  host_idx = '0;
    logic [15:0] host_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        seg_start;
    logic [3:0]  cur_slot;
    logic        cur_tx_act, cur_rx_act, cur_linked;
    logic [3:0]  cur_chan;
    logic        busy, poll;

    slot_activation_seq i_slot_activation_seq (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_cmd(host_cmd), .host_sel(host_sel), .host_idx(host_idx),
        .host_wdata(host_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .seg_start(seg_start), .cur_slot(cur_slot), .cur_tx_act(cur_tx_act),
        .cur_rx_act(cur_rx_act), .cur_linked(cur_linked), .cur_chan(cur_chan),
        .busy(busy), .poll(poll)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // reference model
    int m_tx[NS], m_rx[NS], m_lnk[NS], m_ptr[NS], m_cwv[NS], m_cw[NS];
    int m_chan[NC][NK];
    int m_dflt[2][NK];
    int exp_slot = 0, exp_busy = 0, busy_cnt = 0, poll_cnt = 0;
    bit seen_first = 0;
    bit req_pend = 0;
    int r_cmd, r_sel, r_idx, r_data;
    bit rd_due = 0;
    int exp_rd = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int mk_cw(int go, int mc, int df, int txo, int rxo, int ch);
        return (go & 1) | ((mc & 1) << 1) | ((df & 3) << 2) | ((txo & 1) << 4)
             | ((rxo & 1) << 5) | ((ch & 15) << 8);
    endfunction

    // R4 R5 R6 R7 R8: apply a queued word at the slot's segment start
    task automatic model_apply(input int s);
        int w, inact, df, ch, t;
        exp_busy = 0;
        if (m_cwv[s] == 0) return;
        m_cwv[s] = 0;
        w = m_cw[s];
        inact = !(m_tx[s] == 1 && m_rx[s] == 1);
        df = (w >> 2) & 3;
        ch = (w >> 8) & 15;
        if (inact && ((w >> 1) & 1) == 1) begin
            m_ptr[s] = ch;
            m_lnk[s] = 1;
            if (df != 0) begin
                t = (df & 1) ? 0 : 1;
                for (int i = 0; i < NK; i++) m_chan[ch][i] = m_dflt[t][i];
                exp_busy = NK;
            end
        end
        if (inact && (w & 1) == 1) begin
            m_tx[s] = 1;
            m_rx[s] = 1;
        end
        if (((w >> 4) & 1) == 1) m_tx[s] = 0;
        if (((w >> 5) & 1) == 1) m_rx[s] = 0;
    endtask

    task automatic model_serve();
        case (r_cmd)
            0: begin m_cw[r_sel] = r_data; m_cwv[r_sel] = 1; end   // R11 newest wins
            1: m_chan[r_sel][r_idx] = r_data;
            2: m_dflt[r_sel & 1][r_idx] = r_data;
            default: begin exp_rd = m_chan[r_sel][r_idx]; rd_due = 1; end
        endcase
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (seg_start) begin
                check(cur_slot == 4'(exp_slot), "R1 slot order", cur_slot, exp_slot);
                if (seen_first) begin
                    check(busy_cnt == exp_busy, "R5 busy length", busy_cnt, exp_busy);
                    check(poll_cnt == 1, "R2 polls per segment", poll_cnt, 1);
                end else begin
                    check(host_ready == 1'b1, "R9 ready after reset", host_ready, 1);
                    check(busy == 1'b0, "R9 busy after reset", busy, 0);
                end
                check(cur_tx_act == m_tx[exp_slot][0], "R6 R7 R8 R9 tx state", cur_tx_act, m_tx[exp_slot]);
                check(cur_rx_act == m_rx[exp_slot][0], "R6 R7 R8 R9 rx state", cur_rx_act, m_rx[exp_slot]);
                check(cur_linked == m_lnk[exp_slot][0], "R4 R8 linked", cur_linked, m_lnk[exp_slot]);
                check(cur_chan == 4'(m_ptr[exp_slot]), "R4 R8 pointer", cur_chan, m_ptr[exp_slot]);
                model_apply(exp_slot);
                exp_slot = (exp_slot + 1) % NS;
                busy_cnt = 0;
                poll_cnt = 0;
                seen_first = 1;
            end
            if (busy) busy_cnt++;
            if (rd_valid) begin
                check(rd_due, "R10 unexpected read strobe", 1, 0);
                check(rd_data == 16'(exp_rd), "R10 R3 read data", rd_data, exp_rd);
                rd_due = 0;
            end
            if (poll) begin
                poll_cnt++;
                if (req_pend) begin
                    model_serve();
                    req_pend = 0;
                end
            end
        end
    end

    task automatic send(input int cmd, input int sel, input int idx, input int data);
        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid = 1'b1;
        host_cmd   = 2'(cmd);
        host_sel   = 4'(sel);
        host_idx   = 4'(idx);
        host_wdata = 16'(data);
        r_cmd = cmd; r_sel = sel; r_idx = idx; r_data = data;
        @(posedge clk);
        #1;
        host_valid = 1'b0;
        req_pend = 1;
        check(host_ready == 1'b0, "R2 request held pending", host_ready, 0);
    endtask

    task automatic wait_slot(input int s);
        @(negedge clk);
        while (!(seg_start && cur_slot == 4'(s))) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int s = 0; s < NS; s++) begin
            m_tx[s] = 0; m_rx[s] = 0; m_lnk[s] = 0; m_ptr[s] = 0; m_cwv[s] = 0; m_cw[s] = 0;
        end
        for (int c = 0; c < NC; c++) for (int i = 0; i < NK; i++) m_chan[c][i] = 0;
        for (int t = 0; t < 2; t++) for (int i = 0; i < NK; i++) m_dflt[t][i] = 0;
        repeat (3) @(negedge clk);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R3 default tables with distinct patterns
        for (int i = 0; i < NK; i++) send(2, 0, i, 16'h1000 + i);
        for (int i = 0; i < NK; i++) send(2, 1, i, 16'h2000 + 3 * i);
        // R3 R10 channel 5 from scratch, then read back
        for (int i = 0; i < NK; i++) send(1, 5, i, 16'hA500 + i);
        send(3, 5, 0, 0);
        send(3, 5, 15, 0);
        // R5 both tables selected: table 0 wins; R4 R6 link and power up
        send(0, 3, 0, mk_cw(1, 1, 3, 0, 0, 7));
        wait_slot(4);
        send(3, 7, 0, 0);
        send(3, 7, 15, 0);
        // R8 active slot ignores link, table select
        send(0, 3, 0, mk_cw(1, 1, 2, 0, 0, 2));
        wait_slot(4);
        send(3, 2, 4, 0);
        // R7 TX only shutdown
        send(0, 3, 0, mk_cw(0, 0, 0, 1, 0, 0));
        wait_slot(4);
        // R7 shutdown overrides power-up in same word
        send(0, 6, 0, mk_cw(1, 1, 0, 0, 1, 9));
        // R11 two words to slot 12 before it is reached
        wait_slot(0);
        send(0, 12, 0, mk_cw(1, 1, 1, 0, 0, 1));
        send(0, 12, 0, mk_cw(0, 1, 2, 0, 0, 4));
        wait_slot(13);
        send(3, 4, 3, 0);

        // random mix
        for (int n = 0; n < 1100; n++) begin
            int k, cmd, sel, idx, data;
            k = $urandom_range(0, 9);
            cmd = (k < 4) ? 0 : (k < 6) ? 1 : (k < 7) ? 2 : 3;
            sel = $urandom_range(0, 15);
            idx = $urandom_range(0, 15);
            if (cmd == 0)
                data = mk_cw($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3),
                             ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                             $urandom_range(0, 15));
            else
                data = $urandom_range(0, 65535);
            send(cmd, sel, idx, data);
        end

        repeat (2 * NS * SEG + 4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

endmodule